// File: doc/BRIEF.md
# PLL Power Sequencer

This block steps an analog PLL macro through a safe power-up and power-down order. It drives three control lines to the macro: a bypass-release line, an active-low reset release and an output gate. Enable and disable requests arrive as single-cycle pulses. All waiting is measured in pulses of a one-microsecond tick input, so the sequence timing does not depend on the system clock frequency. The lock-detect and voted-active status inputs come from other clock domains and are resynchronised inside the block.

A mode input selects between two ways of working. In direct mode the block runs the full sequence. On enable it releases bypass, waits, releases reset, polls lock with a bounded number of samples and finally opens the output gate. On disable it closes the gate, waits briefly, then drops both releases. In voting mode the block only raises or lowers a vote line. On enable it also polls a shared "active" flag, because another agent does the actual sequencing.

A request that arrives while a sequence runs is held and served once the running sequence ends. A lock poll that runs out sets a sticky error flag. The next accepted request clears that flag.

Top module: `pllseq_top`

## Requirements
- R1: On a direct-mode enable, bypass_rel rises first. reset_rel rises in the cycle after the (GAP_US+1)-th us_tick pulse that follows the rise of bypass_rel, which guarantees at least GAP_US microseconds between the two.
- R2: After reset release, the synchronised lock status is sampled once on each us_tick pulse. If POLL_MAX samples in a row read low, the sequence ends with timeout_err set and busy low.
- R3: out_gate rises only on a tick whose lock sample reads high. It is the last enable step. done pulses for one cycle in that same cycle and busy drops with it.
- R4: A direct-mode enable that finds bypass_rel, reset_rel and out_gate all high pulses done without changing any output and without going busy.
- R5: In voting mode, an enable raises vote_out and polls the synchronised vote_active on each tick, under the same POLL_MAX limit. A disable drops vote_out and pulses done at once. Neither request touches bypass_rel, reset_rel or out_gate.
- R6: A direct-mode disable first drops out_gate. In the cycle after the (SETTLE_US+1)-th following tick, bypass_rel and reset_rel fall together and done pulses.
- R7: A request that arrives while busy is stored. The newest request wins, and an enable wins over a disable in the same cycle. The stored request starts in the cycle after the running sequence ends.
- R8: lock_det and vote_active each pass through two flops before use. A change driven in the same cycle as a tick is not seen by that tick.
- R9: A timeout leaves bypass_rel and reset_rel high, out_gate low and vote_out unchanged. timeout_err stays high until the next request is accepted, which clears it.
- R10: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| vote_mode | input | 1 | 1 = voting mode, 0 = direct sequencing |
| en_req | input | 1 | Enable request pulse |
| dis_req | input | 1 | Disable request pulse |
| lock_det | input | 1 | PLL lock indicator, asynchronous |
| vote_active | input | 1 | Voted-active flag, asynchronous |
| bypass_rel | output | 1 | Bypass release to the PLL |
| reset_rel | output | 1 | Reset release to the PLL (active-low reset deasserted) |
| out_gate | output | 1 | PLL output gate enable |
| vote_out | output | 1 | Vote line in voting mode |
| done | output | 1 | One-cycle pulse when a sequence completes |
| busy | output | 1 | A sequence is in progress |
| timeout_err | output | 1 | Sticky lock/active poll timeout |

## Verification
A request pulse is stored at the first clock edge. The state machine accepts it at the second edge, so the first output change is visible two edges after the pulse. After that, each step lands at the edge that samples the deciding tick pulse, and done pulses at that same edge. A status input change reaches the poll logic two edges after it is driven. The bench therefore drives every input just after a falling edge and samples only at falling edges. It waits a fixed three cycles after each request and two cycles after each tick, and counts done pulses at falling edges over each step, so no check lands on an edge where an output is still settling.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GAP,
    ST_LOCK,
    ST_SETTLE,
    ST_VOTE
  } seq_state_e;

  // Wait window over once the counter has reached the limit.
  function automatic logic span_done(input logic [31:0] cnt, input logic [31:0] lim);
    return cnt >= lim;
  endfunction

  // Direct-mode "already running" test.
  function automatic logic fully_on(input logic byp, input logic rel, input logic gate);
    return byp & rel & gate;
  endfunction

endpackage

// File: rtl/pllseq_sync.sv
module pllseq_sync #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= din;
      sync_q <= meta_q;
    end
  end

  assign dout = sync_q;

endmodule

// File: rtl/pllseq_req_hold.sv
module pllseq_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  input  logic take,
  output logic pend_valid,
  output logic pend_dis
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_dis   <= 1'b0;
    end else if (en_req) begin
      pend_valid <= 1'b1;
      pend_dis   <= 1'b0;
    end else if (dis_req) begin
      pend_valid <= 1'b1;
      pend_dis   <= 1'b1;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // R7: any request is held for the state machine
  p_request_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_req || dis_req) |=> pend_valid);

  // R7: enable wins over a simultaneous disable
  p_enable_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_req |=> !pend_dis);

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
#(
  parameter int unsigned GAP_US    = 5,
  parameter int unsigned SETTLE_US = 1,
  parameter int unsigned POLL_MAX  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic vote_mode,
  input  logic pend_valid,
  input  logic pend_dis,
  input  logic lock_s,
  input  logic act_s,
  output logic take,
  output logic bypass_rel,
  output logic reset_rel,
  output logic out_gate,
  output logic vote_out,
  output logic done,
  output logic busy,
  output logic timeout_err
);

  localparam int unsigned LIM_A  = (GAP_US > SETTLE_US) ? GAP_US + 1 : SETTLE_US + 1;
  localparam int unsigned MAXLIM = (LIM_A > POLL_MAX) ? LIM_A : POLL_MAX;
  localparam int unsigned CNT_W  = $clog2(MAXLIM + 1);

  seq_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;

  // named events for the assertions
  logic poll_tick;
  logic poll_hit;
  logic poll_expired;
  logic start_seq;

  assign take         = (state_q == ST_IDLE) && pend_valid;
  assign start_seq    = take;
  assign poll_tick    = us_tick && ((state_q == ST_LOCK) || (state_q == ST_VOTE));
  assign poll_hit     = poll_tick && ((state_q == ST_LOCK) ? lock_s : act_s);
  assign poll_expired = poll_tick && !poll_hit && span_done(32'(cnt_q), 32'(POLL_MAX - 1));
  assign busy         = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      cnt_q       <= '0;
      bypass_rel  <= 1'b0;
      reset_rel   <= 1'b0;
      out_gate    <= 1'b0;
      vote_out    <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_seq) begin
            timeout_err <= 1'b0;
            cnt_q       <= '0;
            if (vote_mode) begin
              if (pend_dis) begin
                vote_out <= 1'b0;
                done     <= 1'b1;
              end else begin
                vote_out <= 1'b1;
                state_q  <= ST_VOTE;
              end
            end else if (pend_dis) begin
              out_gate <= 1'b0;
              state_q  <= ST_SETTLE;
            end else if (fully_on(bypass_rel, reset_rel, out_gate)) begin
              done <= 1'b1;
            end else begin
              bypass_rel <= 1'b1;
              state_q    <= ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (us_tick) begin
            if (span_done(32'(cnt_q), 32'(GAP_US))) begin
              reset_rel <= 1'b1;
              cnt_q     <= '0;
              state_q   <= ST_LOCK;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_LOCK, ST_VOTE: begin
          if (poll_hit) begin
            if (state_q == ST_LOCK) out_gate <= 1'b1;
            done    <= 1'b1;
            state_q <= ST_IDLE;
          end else if (poll_expired) begin
            timeout_err <= 1'b1;
            state_q     <= ST_IDLE;
          end else if (poll_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_SETTLE: begin
          if (us_tick) begin
            if (span_done(32'(cnt_q), 32'(SETTLE_US))) begin
              bypass_rel <= 1'b0;
              reset_rel  <= 1'b0;
              done       <= 1'b1;
              state_q    <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Assertion support: ticks seen since bypass release rose (saturating).
  logic [CNT_W-1:0] gap_ticks_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                           gap_ticks_q <= '0;
    else if (!bypass_rel)                                 gap_ticks_q <= '0;
    else if (us_tick && (gap_ticks_q < CNT_W'(GAP_US + 1))) gap_ticks_q <= gap_ticks_q + 1'b1;
  end

  // R1: reset release only after the full gap since bypass release
  p_gap_before_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_rel) |-> bypass_rel && (32'(gap_ticks_q) > GAP_US));

  // R3: gate opens only with confirmed lock and both releases up
  p_gate_after_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_gate) |-> $past(lock_s) && bypass_rel && reset_rel && done);

  // R6: releases fall together, with the gate already closed
  p_release_drop_together_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bypass_rel) |-> $fell(reset_rel) && !out_gate);

  // R9: a timeout leaves the gate closed and the sequencer idle
  p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> !busy && !out_gate && reset_rel == $past(reset_rel));

  // R2: a poll that expires never completes in the same step
  p_expire_no_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expired |=> !done && timeout_err);

endmodule

// File: rtl/pllseq_top.sv
module pllseq_top #(
  parameter int unsigned GAP_US    = 5,
  parameter int unsigned SETTLE_US = 1,
  parameter int unsigned POLL_MAX  = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic vote_mode,
  input  logic en_req,
  input  logic dis_req,
  input  logic lock_det,
  input  logic vote_active,
  output logic bypass_rel,
  output logic reset_rel,
  output logic out_gate,
  output logic vote_out,
  output logic done,
  output logic busy,
  output logic timeout_err
);

  localparam int unsigned N_STAT = 2;

  logic [N_STAT-1:0] stat_raw;
  logic [N_STAT-1:0] stat_s;
  logic pend_valid;
  logic pend_dis;
  logic take;

  assign stat_raw = {vote_active, lock_det};

  pllseq_sync #(.W(N_STAT)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (stat_raw),
    .dout (stat_s)
  );

  pllseq_req_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req),
    .dis_req   (dis_req),
    .take      (take),
    .pend_valid(pend_valid),
    .pend_dis  (pend_dis)
  );

  pllseq_fsm #(
    .GAP_US   (GAP_US),
    .SETTLE_US(SETTLE_US),
    .POLL_MAX (POLL_MAX)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .vote_mode  (vote_mode),
    .pend_valid (pend_valid),
    .pend_dis   (pend_dis),
    .lock_s     (stat_s[0]),
    .act_s      (stat_s[1]),
    .take       (take),
    .bypass_rel (bypass_rel),
    .reset_rel  (reset_rel),
    .out_gate   (out_gate),
    .vote_out   (vote_out),
    .done       (done),
    .busy       (busy),
    .timeout_err(timeout_err)
  );

endmodule

// File: tb/pllseq_top_tb_top.sv
`timescale 1ns/1ps
module pllseq_top_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0, vote_mode = 1'b0, en_req = 1'b0, dis_req = 1'b0;
  logic lock_det = 1'b0, vote_active = 1'b0;
  logic bypass_rel, reset_rel, out_gate, vote_out, done, busy, timeout_err;

  always #5 clk = ~clk;

  pllseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .vote_mode(vote_mode),
    .en_req(en_req), .dis_req(dis_req), .lock_det(lock_det), .vote_active(vote_active),
    .bypass_rel(bypass_rel), .reset_rel(reset_rel), .out_gate(out_gate),
    .vote_out(vote_out), .done(done), .busy(busy), .timeout_err(timeout_err)
  );

  int errors = 0;
  int checks = 0;
  int done_cnt = 0;
  int cycles = 0;
  bit finished = 0;

  always @(negedge clk) if (done) done_cnt++;

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired: actual hung, expected finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // req: 0 none, 1 enable, 2 disable; exp = {byp, rel, gate, vote, busy, err}
  typedef struct packed {
    logic       mode;
    logic       lock;
    logic       act;
    logic [1:0] req;
    logic [7:0] ticks;
    logic [5:0] exp;
    logic [1:0] ndone;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TAB [NV] = '{
    '{1'b0,1'b1,1'b0,2'd1,8'd0,  6'b100010,2'd0,4'd1},  // R1 bypass first
    '{1'b0,1'b1,1'b0,2'd0,8'd5,  6'b100010,2'd0,4'd1},  // R1 five ticks: reset still held
    '{1'b0,1'b1,1'b0,2'd0,8'd1,  6'b110010,2'd0,4'd1},  // R1 sixth tick releases reset
    '{1'b0,1'b1,1'b0,2'd0,8'd1,  6'b111000,2'd1,4'd3},  // R3 lock seen -> gate, done
    '{1'b0,1'b1,1'b0,2'd1,8'd0,  6'b111000,2'd1,4'd4},  // R4 already on -> immediate done
    '{1'b0,1'b1,1'b0,2'd2,8'd0,  6'b110010,2'd0,4'd6},  // R6 gate dropped first
    '{1'b0,1'b1,1'b0,2'd0,8'd1,  6'b110010,2'd0,4'd6},  // R6 one tick: releases held
    '{1'b0,1'b1,1'b0,2'd0,8'd1,  6'b000000,2'd1,4'd6},  // R6 both releases fall
    '{1'b0,1'b0,1'b0,2'd1,8'd6,  6'b110010,2'd0,4'd2},  // R2 in lock poll
    '{1'b0,1'b0,1'b0,2'd0,8'd99, 6'b110010,2'd0,4'd2},  // R2 99 misses: still polling
    '{1'b0,1'b0,1'b0,2'd0,8'd1,  6'b110001,2'd0,4'd9},  // R9 100th miss -> timeout
    '{1'b0,1'b1,1'b0,2'd1,8'd7,  6'b111000,2'd1,4'd9},  // R9 error cleared, relock
    '{1'b0,1'b1,1'b0,2'd2,8'd2,  6'b000000,2'd1,4'd6},  // R6 full disable
    '{1'b1,1'b0,1'b1,2'd1,8'd0,  6'b000110,2'd0,4'd5},  // R5 vote raised
    '{1'b1,1'b0,1'b1,2'd0,8'd1,  6'b000100,2'd1,4'd5},  // R5 active seen
    '{1'b1,1'b0,1'b1,2'd2,8'd0,  6'b000000,2'd1,4'd5},  // R5 vote dropped at once
    '{1'b1,1'b0,1'b0,2'd1,8'd100,6'b000101,2'd0,4'd2},  // R2 vote poll timeout
    '{1'b1,1'b0,1'b0,2'd2,8'd0,  6'b000000,2'd1,4'd9}   // R9 error cleared by request
  };

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) us_tick = 1'b1;
      @(negedge clk) us_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic request(input logic [1:0] kind);
    @(negedge clk);
    en_req  = (kind == 2'd1);
    dis_req = (kind == 2'd2);
    @(negedge clk);
    en_req = 1'b0; dis_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] outs();
    return {bypass_rel, reset_rel, out_gate, vote_out, busy, timeout_err};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 reset outputs", {26'd0, outs()}, 32'd0);
    check("R10 reset done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      vote_mode   = TAB[v].mode;
      lock_det    = TAB[v].lock;
      vote_active = TAB[v].act;
      repeat (4) @(negedge clk);
      done_cnt = 0;
      if (TAB[v].req != 2'd0) request(TAB[v].req);
      tick_n(int'(TAB[v].ticks));
      checks++;
      if (outs() !== TAB[v].exp || done_cnt != int'(TAB[v].ndone)) begin
        errors++;
        $display("FAIL vector %0d R%0d: actual outs=%b done=%0d expected outs=%b done=%0d",
                 v, TAB[v].rq, outs(), done_cnt, TAB[v].exp, TAB[v].ndone);
      end
    end

    // R8: status change in the same cycle as a tick is not seen
    vote_mode = 1'b0; lock_det = 1'b0;
    repeat (4) @(negedge clk);
    request(2'd1);
    tick_n(6);
    @(negedge clk) begin lock_det = 1'b1; us_tick = 1'b1; end
    @(negedge clk) us_tick = 1'b0;
    @(negedge clk);
    check("R8 fresh lock not sampled", {31'd0, out_gate}, 32'd0);
    tick_n(1);
    check("R8 lock seen after sync", {31'd0, out_gate}, 32'd1);

    // R7: disable issued while an enable runs is served afterwards
    request(2'd2);
    tick_n(2);
    check("R7 setup off", {26'd0, outs()}, 32'd0);
    done_cnt = 0;
    request(2'd1);
    request(2'd2);
    check("R7 busy while queued", {31'd0, busy}, 32'd1);
    tick_n(7);
    check("R7 queued disable started", {26'd0, outs()}, {26'd0, 6'b110010});
    tick_n(2);
    check("R7 queued disable finished", {26'd0, outs()}, 32'd0);
    check("R7 two completions", done_cnt, 32'd2);

    // R7: enable wins over disable in the same cycle
    @(negedge clk) begin en_req = 1'b1; dis_req = 1'b1; end
    @(negedge clk) begin en_req = 1'b0; dis_req = 1'b0; end
    repeat (2) @(negedge clk);
    check("R7 enable priority", {31'd0, bypass_rel}, 32'd1);
    tick_n(7);
    check("R3 sequence end", {26'd0, outs()}, {26'd0, 6'b111000});

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule